// File: doc/BRIEF.md
# Receive Character Buffer with Line Status

This block is the receive-side character store of a 16550-style serial port. A deserializer hands it one received character per single-cycle push pulse, together with three condition bits for that character: framing error, parity error and break. A register read removes the oldest character with a single-cycle pop. The block shows the oldest stored entry, the number of stored entries, a data-ready flag and a sticky overrun flag.

The hard case is a push and a pop in the same clock cycle. This happens often at high line rates. In that cycle the count must stay the same, and the new character must keep its condition bits. Data-ready must stay asserted when exactly one entry was present. Overrun must not be raised when the buffer is full, because a slot is being freed in that cycle.

Top module: `rx_fifo_status`

## Requirements
- R1: While `rst_n` is low, `count`, `data_ready`, `overrun`, `head_data` and `head_cond` are all zero.
- R2: Entries leave in the order they were pushed. While `count` is non-zero, `head_data`/`head_cond` show the oldest entry without any added latency. While `count` is zero, both read as zero.
- R3: A push and a pop in the same cycle with `count` non-zero leave `count` unchanged. The oldest entry is removed, and the pushed character is appended with its condition bits exactly as given (bit 0 framing, bit 1 parity, bit 2 break).
- R4: `data_ready` rises one cycle after `count` goes from zero to non-zero. It falls at the edge where `count` is 1, `pop` is high and `push` is low. A push and a pop together at `count` 1 keep it high.
- R5: `count` stays within 0 to DEPTH (16). It rises by one on a push alone and falls by one on a pop alone.
- R6: `overrun` is set only by a push that arrives while `count` equals DEPTH with no pop in the same cycle. That push is discarded, and the stored contents and `count` stay unchanged.
- R7: `overrun` stays set until `stat_clr` or `fifo_clr` is high at a clock edge. A clear wins over a set in the same cycle.
- R8: A pop while `count` is zero is ignored. A push and a pop together while empty store the pushed entry.
- R9: `fifo_clr` empties the buffer and clears `data_ready` and `overrun` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_clr | input | 1 | Synchronous buffer/receiver reset |
| stat_clr | input | 1 | Clears the overrun flag |
| push | input | 1 | Single-cycle write strobe |
| push_data | input | 8 | Received character |
| push_cond | input | 3 | Condition bits: [0] framing, [1] parity, [2] break |
| pop | input | 1 | Single-cycle read strobe |
| head_data | output | 8 | Oldest stored character |
| head_cond | output | 3 | Condition bits of the oldest character |
| count | output | 5 | Number of stored entries |
| data_ready | output | 1 | Data-ready status flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Directed runs fill the buffer to sixteen entries in order and then push into the full buffer, once without a pop and once with a pop. This separates the discard-and-flag case from the legal simultaneous case. A push and a pop together at exactly one entry, carrying non-zero condition bits, shows whether data-ready survives and whether the new entry's bits are kept intact. Pops on an empty buffer, with and without a push, show that empty reads are ignored. A long constrained-random phase mixes pushes, pops, status clears and buffer clears at every fill level. Each output is compared every cycle against a queue model in the bench, which exposes pointer, count and flag errors that appear only after wrap-around.

// File: rtl/rx_fifo_status.sv
module rx_fifo_status #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          stat_clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [CW-1:0] push_cond,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] head_cond,
  output logic [NW-1:0] count,
  output logic          data_ready,
  output logic          overrun
);

  logic [DW+CW-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic             ne_q;

  wire full    = (count == NW'(DEPTH));
  wire empty   = (count == '0);
  wire do_pop  = pop & ~empty;
  wire do_push = push & (~full | do_pop);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {push_cond, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (fifo_clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_push & ~do_pop)      count <= count + 1'b1;
      else if (do_pop & ~do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q       <= 1'b0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
    end else if (fifo_clr) begin
      ne_q       <= 1'b0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      ne_q <= ~empty;
      if (count == NW'(1) && pop && !push) data_ready <= 1'b0;
      else if (~empty & ~ne_q)             data_ready <= 1'b1;
      if (stat_clr)                      overrun <= 1'b0;
      else if (push & ~pop & full)       overrun <= 1'b1;
    end
  end

  assign head_data = empty ? '0 : mem[rd_ptr][DW-1:0];
  assign head_cond = empty ? '0 : mem[rd_ptr][DW+CW-1:DW];

endmodule

// File: rtl/rx_fifo_status_chk.sv
module rx_fifo_status_chk #(
  parameter int DEPTH = 16,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          stat_clr,
  input logic          push,
  input logic          pop,
  input logic [NW-1:0] count,
  input logic          data_ready,
  input logic          overrun
);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));

  a_r3_same_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && count != '0 && !fifo_clr) |=> $stable(count));

  a_r4_ready_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && count == NW'(1) && push && pop && !fifo_clr) |=> data_ready);

  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push && !pop && count == NW'(DEPTH)));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_clr && !fifo_clr) |=> overrun);

  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !push && !fifo_clr) |=> count == '0);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (count == '0 && !data_ready && !overrun));

endmodule

bind rx_fifo_status rx_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .stat_clr(stat_clr),
  .push(push), .pop(pop), .count(count), .data_ready(data_ready),
  .overrun(overrun)
);

// File: tb/rx_fifo_status_tb.sv
`timescale 1ns/1ps
module rx_fifo_status_tb;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_clr = 0, stat_clr = 0, push = 0, pop = 0;
  logic [7:0] push_data = '0;
  logic [2:0] push_cond = '0;
  logic [7:0] head_data;
  logic [2:0] head_cond;
  logic [4:0] count;
  logic data_ready, overrun;

  always #2 clk = ~clk;

  rx_fifo_status u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .stat_clr(stat_clr),
    .push(push), .push_data(push_data), .push_cond(push_cond), .pop(pop),
    .head_data(head_data), .head_cond(head_cond), .count(count),
    .data_ready(data_ready), .overrun(overrun)
  );

  int checks = 0, failures = 0;
  logic [10:0] q [DEPTH];
  int qn = 0;
  logic e_dr = 0, e_ov = 0, e_ned = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_head();
    return (qn == 0) ? 0 : int'(q[0]);
  endfunction

  task automatic compare();
    chk("R5 count", count, qn);
    chk("R2 head", {head_cond, head_data}, exp_head());
    chk("R4 data_ready", data_ready, e_dr);
    chk("R6/R7 overrun", overrun, e_ov);
  endtask

  task automatic model(input logic ps, input logic [10:0] ent, input logic pp,
                       input logic fc, input logic sc);
    logic ne = (qn != 0);
    logic dpop = pp && qn != 0;
    logic dpush = ps && (qn < DEPTH || dpop);
    if (fc) begin
      qn = 0; e_dr = 0; e_ov = 0; e_ned = 0;
      return;
    end
    if (qn == 1 && pp && !ps) e_dr = 0;
    else if (ne && !e_ned)    e_dr = 1;
    if (sc) e_ov = 0;
    else if (ps && !pp && qn == DEPTH) e_ov = 1;
    e_ned = ne;
    if (dpop) begin
      for (int i = 0; i < DEPTH - 1; i++) q[i] = q[i+1];
      qn--;
    end
    if (dpush) begin
      q[qn] = ent;
      qn++;
    end
  endtask

  task automatic cyc(input logic ps, input logic [7:0] d, input logic [2:0] c,
                     input logic pp, input logic fc = 0, input logic sc = 0);
    @(negedge clk);
    compare();
    push = ps; push_data = d; push_cond = c; pop = pp;
    fifo_clr = fc; stat_clr = sc;
    model(ps, {c, d}, pp, fc, sc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 head", {head_cond, head_data}, 0);
    rst_n = 1'b1;

    // R2: fill to full in order
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(8'h40 + i), 3'(i), 0);
    // R6: push into full without pop
    cyc(1, 8'hEE, 3'b111, 0);
    cyc(0, 0, 0, 0);
    chk("R6 full kept", count, DEPTH);
    chk("R6 overrun set", overrun, 1);
    // R7: sticky, then status clear
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk("R7 cleared", overrun, 0);
    // R3/R6: push and pop while full
    cyc(1, 8'hA5, 3'b010, 1);
    cyc(0, 0, 0, 0);
    chk("R6 no overrun on pop", overrun, 0);
    chk("R3 full count", count, DEPTH);
    // drain
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1);
    // R8: pops while empty, then push+pop while empty
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(1, 8'h3C, 3'b001, 1);
    cyc(0, 0, 0, 0);
    chk("R8 push kept", count, 1);
    // R4/R3: push and pop at count 1 with condition bits
    cyc(0, 0, 0, 0);
    cyc(1, 8'h77, 3'b101, 1);
    cyc(0, 0, 0, 0);
    chk("R4 ready kept", data_ready, 1);
    chk("R3 cond kept", head_cond, 3'b101);
    chk("R3 data", head_data, 8'h77);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk("R4 ready falls", data_ready, 0);
    // R9: clear a partly filled buffer
    for (int i = 0; i < 5; i++) cyc(1, 8'(i), 3'b100, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk("R9 cleared count", count, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      int fill = (n / 500) % 2;
      logic ps = (r < (fill ? 70 : 40));
      logic pp = (int'($urandom_range(0, 99)) < (fill ? 35 : 60));
      logic fc = ($urandom_range(0, 199) == 0);
      logic sc = ($urandom_range(0, 29) == 0);
      cyc(ps, 8'($urandom), 3'($urandom), pp, fc, sc);
    end
    cyc(0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule